// File: doc/BRIEF.md
# Ethernet Receive Frame Queue

This block sits between a receive MAC datapath and a processor. Incoming frames arrive as a byte stream with first-byte and last-byte markers. The checksum for each frame is presented together with its last byte. Each accepted frame is written whole into one slot of a circular set of frame slots. The frame is stored as a little-endian 16-bit length word, then the payload bytes, then the four checksum bytes (least significant byte first), then zero bytes up to the next 32-bit boundary. The stored length is the payload size plus 6.

The processor drains the queue one 32-bit word per read strobe, from a single data port. A frame leaves the queue only when its final word has been read. A pending-frame count and an interrupt level tell software when data is waiting. Two one-cycle events report a stored frame and a frame rejected for being too large. A clear input discards every queued frame and restarts the read position.

The slot count and the slot size in bytes are parameters. The default is 31 slots of 256 bytes. The oversize limit is always the slot size minus 6.

Top module: `rx_frame_queue`

## Requirements
- R1: Up to SLOTS frames are held and read out in arrival order. The write slot is (head + pending) mod SLOTS, and the head index wraps from SLOTS-1 to 0.
- R2: A frame whose first byte arrives while `rx_en` is low is discarded entirely, and `frames_pending` does not change.
- R3: A frame whose first byte arrives while `frames_pending` equals SLOTS is discarded, and the queue content is unchanged.
- R4: A frame of SLOT_BYTES-6 or more payload bytes is not stored. `overflow_evt` is high for exactly the one cycle after the clock edge that takes its last byte. A frame one byte shorter is stored normally.
- R5: The stored byte image is laid out as follows:
  - byte 0 = (size+6) mod 256 and byte 1 = (size+6)/256;
  - bytes 2..size+1 are the payload in arrival order;
  - the next four bytes are `in_crc` bits 7:0, 15:8, 23:16 and 31:24;
  - the rest of the final word is zero.
- R6: A `rd_strobe` pulse while a frame is pending places on `rd_word`, from the following clock edge on, image bytes 4k..4k+3 of the head frame with byte 4k in bits 7:0. Here k counts the reads already made from that frame. `rd_word` then holds until the next strobe.
- R7: The read that returns the word containing the last image byte (word ceil((size+6)/4)-1) decrements `frames_pending` and moves the head to the next frame. The next read returns that frame's word 0.
- R8: A `fifo_clr` cycle sets `frames_pending` to 0 and the read position to word 0, and abandons a frame still being written. The next frame received is stored and read back intact.
- R9: `rx_irq` is high exactly when `frames_pending` is nonzero.
- R10: A `rd_strobe` while no frame is pending makes `rd_word` zero and leaves `frames_pending` and the read position unchanged.
- R11: A stored frame is committed six clock edges after the edge that takes its last byte. `frame_stored` is high for the one cycle after the commit, and `frames_pending` is incremented at the commit. The source must leave at least 7 idle cycles after a last byte before the next first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A receive byte is present this cycle |
| in_first | input | 1 | Present byte is the first of a frame |
| in_last | input | 1 | Present byte is the last of a frame |
| in_byte | input | 8 | Receive byte |
| in_crc | input | 32 | Frame checksum, sampled with the last byte |
| rx_en | input | 1 | Receive enable, sampled at each first byte |
| fifo_clr | input | 1 | Discard all queued frames and the read position |
| rd_strobe | input | 1 | Read one word from the head frame |
| rd_word | output | 32 | Word returned by the latest read |
| frames_pending | output | $clog2(SLOTS+1) | Number of complete frames queued |
| rx_irq | output | 1 | Frames are pending |
| frame_stored | output | 1 | One-cycle event: a frame was committed |
| overflow_evt | output | 1 | One-cycle event: an oversize frame was rejected |

## Verification
A read result is due one clock edge after its strobe, and the pending count moves on that same edge. The bench therefore raises the strobe at a falling edge and samples both values at the next falling edge. A stored frame becomes visible six edges after its last byte, and an overflow event one edge after it. The bench waits ten idle cycles after every frame before it checks the count. The two events are tallied by a falling-edge monitor, so that each pulse is compared as a count change across the frame.

// File: rtl/rfq_pkg.sv
package rfq_pkg;
   typedef enum logic [2:0] {
      W_IDLE,
      W_DATA,
      W_DROP,
      W_CRC,
      W_PAD,
      W_HDR
   } wr_state_t;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned HDR_EXTRA  = 6;
endpackage

// File: rtl/rfq_slot_mem.sv
module rfq_slot_mem #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata
);
   logic [31:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/rfq_packer.sv
module rfq_packer
   import rfq_pkg::*;
#(
   parameter int unsigned SLOTS      = 31,
   parameter int unsigned SLOT_BYTES = 256,
   localparam int unsigned WPS = SLOT_BYTES / WORD_BYTES,
   localparam int unsigned WW  = $clog2(WPS),
   localparam int unsigned SW  = $clog2(SLOTS),
   localparam int unsigned CW  = $clog2(SLOTS + 1),
   localparam int unsigned THR = SLOT_BYTES - HDR_EXTRA
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_first,
   input  logic            in_last,
   input  logic [7:0]      in_byte,
   input  logic [31:0]     in_crc,
   input  logic            rx_en,
   input  logic            fifo_clr,
   input  logic [SW-1:0]   head,
   input  logic [CW-1:0]   pending,
   output logic            we,
   output logic [SW+WW-1:0] waddr,
   output logic [31:0]     wdata,
   output logic            commit,
   output logic            stored_evt,
   output logic            ovf_evt
);
   wr_state_t      state;
   logic [SW-1:0]  slot;
   logic [31:0]    acc, w0, crc_sh;
   logic [1:0]     lane, crc_cnt;
   logic [WW-1:0]  widx;
   logic [15:0]    size;

   logic [SW:0]    slot_sum;
   logic [SW-1:0]  slot_new;
   logic           accept, push, word_full;
   logic [7:0]     push_byte;
   logic [1:0]     base_lane;
   logic [WW-1:0]  base_widx;
   logic [31:0]    base_acc, ins_acc;
   logic [15:0]    size_nx, img_len;

   assign slot_sum = SW'(head) + (SW+1)'(pending);
   assign slot_new = (slot_sum >= (SW+1)'(SLOTS)) ? SW'(slot_sum - (SW+1)'(SLOTS))
                                                  : SW'(slot_sum);
   assign accept   = (state == W_IDLE) && in_valid && in_first && rx_en && !fifo_clr &&
                     (pending < CW'(SLOTS));
   assign size_nx  = (size < 16'(THR)) ? size + 16'd1 : size;
   assign img_len  = size + 16'(HDR_EXTRA);

   always_comb begin
      base_lane = (state == W_IDLE) ? 2'd2 : lane;
      base_widx = (state == W_IDLE) ? '0   : widx;
      base_acc  = (state == W_IDLE) ? '0   : acc;
      push      = 1'b0;
      push_byte = in_byte;
      unique case (state)
         W_IDLE: push = accept;
         W_DATA: push = in_valid && !fifo_clr && (size < 16'(THR));
         W_CRC: begin
            push      = !fifo_clr;
            push_byte = crc_sh[7:0];
         end
         default: push = 1'b0;
      endcase
   end

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign ins_acc[8*g +: 8] = (base_lane == 2'(g)) ? push_byte : base_acc[8*g +: 8];
   end

   assign word_full = push && (base_lane == 2'd3);

   always_comb begin
      we     = 1'b0;
      waddr  = {slot, base_widx};
      wdata  = ins_acc;
      commit = 1'b0;
      if (word_full && base_widx != '0) begin
         we = 1'b1;
      end else if (state == W_PAD && !fifo_clr && lane != 2'd0 && widx != '0) begin
         we    = 1'b1;
         waddr = {slot, widx};
         wdata = acc;
      end else if (state == W_HDR && !fifo_clr) begin
         we     = 1'b1;
         waddr  = {slot, WW'(0)};
         wdata  = {w0[31:16], img_len};
         commit = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= W_IDLE;
         slot       <= '0;
         acc        <= '0;
         w0         <= '0;
         crc_sh     <= '0;
         lane       <= '0;
         crc_cnt    <= '0;
         widx       <= '0;
         size       <= '0;
         stored_evt <= 1'b0;
         ovf_evt    <= 1'b0;
      end else begin
         stored_evt <= commit;
         ovf_evt    <= 1'b0;
         if (push) begin
            if (word_full) begin
               if (base_widx == '0) w0 <= ins_acc;
               acc  <= '0;
               lane <= 2'd0;
               widx <= base_widx + WW'(1);
            end else begin
               acc  <= ins_acc;
               lane <= base_lane + 2'd1;
               widx <= base_widx;
            end
         end
         if (fifo_clr && state != W_IDLE) begin
            state <= W_IDLE;
         end else begin
            unique case (state)
               W_IDLE: begin
                  if (in_valid && in_first) begin
                     if (accept) begin
                        slot    <= slot_new;
                        size    <= 16'd1;
                        crc_sh  <= in_crc;
                        crc_cnt <= '0;
                        state   <= in_last ? W_CRC : W_DATA;
                     end else begin
                        state <= in_last ? W_IDLE : W_DROP;
                     end
                  end
               end
               W_DATA: begin
                  if (in_valid) begin
                     size <= size_nx;
                     if (in_last) begin
                        if (size_nx >= 16'(THR)) begin
                           ovf_evt <= 1'b1;
                           state   <= W_IDLE;
                        end else begin
                           crc_sh  <= in_crc;
                           crc_cnt <= '0;
                           state   <= W_CRC;
                        end
                     end
                  end
               end
               W_DROP: if (in_valid && in_last) state <= W_IDLE;
               W_CRC: begin
                  crc_sh  <= {8'd0, crc_sh[31:8]};
                  crc_cnt <= crc_cnt + 2'd1;
                  if (crc_cnt == 2'd3) state <= W_PAD;
               end
               W_PAD: begin
                  if (lane != 2'd0 && widx == '0) w0 <= acc;
                  state <= W_HDR;
               end
               default: state <= W_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rfq_reader.sv
module rfq_reader #(
   parameter int unsigned SLOTS      = 31,
   parameter int unsigned SLOT_BYTES = 256,
   localparam int unsigned WPS = SLOT_BYTES / 4,
   localparam int unsigned WW  = $clog2(WPS),
   localparam int unsigned SW  = $clog2(SLOTS),
   localparam int unsigned CW  = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_strobe,
   input  logic             fifo_clr,
   input  logic             commit,
   input  logic [31:0]      mem_q,
   output logic [SW-1:0]    head,
   output logic [CW-1:0]    pending,
   output logic             re,
   output logic [SW+WW-1:0] raddr,
   output logic             zero_q
);
   logic [WW-1:0] off;
   logic          hdr_q, last, pop;
   logic [15:0]   cur_len, eff_len;
   logic [16:0]   next_end;
   logic [SW-1:0] head_inc;

   if ((1 << SW) == SLOTS) begin : g_wrap_pow2
      assign head_inc = head + SW'(1);
   end else begin : g_wrap_cmp
      assign head_inc = (head == SW'(SLOTS - 1)) ? '0 : head + SW'(1);
   end

   assign eff_len  = hdr_q ? mem_q[15:0] : cur_len;
   assign next_end = (17'(off) + 17'd1) << 2;
   assign last     = (off != '0) && (next_end >= 17'(eff_len));
   assign re       = rd_strobe && (pending != '0);
   assign pop      = re && last;
   assign raddr    = {head, off};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head    <= '0;
         pending <= '0;
         off     <= '0;
         hdr_q   <= 1'b0;
         cur_len <= '0;
         zero_q  <= 1'b1;
      end else begin
         if (rd_strobe) zero_q <= (pending == '0);
         if (hdr_q) cur_len <= mem_q[15:0];
         if (fifo_clr) begin
            pending <= '0;
            off     <= '0;
            hdr_q   <= 1'b0;
         end else begin
            hdr_q   <= re && (off == '0);
            pending <= pending + CW'(commit) - CW'(pop);
            if (pop) begin
               off  <= '0;
               head <= head_inc;
            end else if (re) begin
               off <= off + WW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
   parameter int unsigned SLOTS      = 31,
   parameter int unsigned SLOT_BYTES = 256,
   localparam int unsigned WPS = SLOT_BYTES / 4,
   localparam int unsigned WW  = $clog2(WPS),
   localparam int unsigned SW  = $clog2(SLOTS),
   localparam int unsigned CW  = $clog2(SLOTS + 1),
   localparam int unsigned AW  = SW + WW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_first,
   input  logic          in_last,
   input  logic [7:0]    in_byte,
   input  logic [31:0]   in_crc,
   input  logic          rx_en,
   input  logic          fifo_clr,
   input  logic          rd_strobe,
   output logic [31:0]   rd_word,
   output logic [CW-1:0] frames_pending,
   output logic          rx_irq,
   output logic          frame_stored,
   output logic          overflow_evt
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("rx_frame_queue: SLOTS must be at least 2");
   end
   if (SLOT_BYTES < 16 || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_size
      $error("rx_frame_queue: SLOT_BYTES must be a power of two of at least 16");
   end
   if (SLOT_BYTES > 65536) begin : g_bad_len
      $error("rx_frame_queue: SLOT_BYTES exceeds the 16-bit length field");
   end

   logic          we, re, commit, zero_q;
   logic [AW-1:0] waddr, raddr;
   logic [31:0]   wdata, mem_q;
   logic [SW-1:0] head;

   rfq_packer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) packer_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_byte(in_byte), .in_crc(in_crc), .rx_en(rx_en),
      .fifo_clr(fifo_clr), .head(head), .pending(frames_pending),
      .we(we), .waddr(waddr), .wdata(wdata), .commit(commit),
      .stored_evt(frame_stored), .ovf_evt(overflow_evt)
   );

   rfq_slot_mem #(.DEPTH(SLOTS * WPS), .AW(AW)) mem_i (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .re(re), .raddr(raddr), .rdata(mem_q)
   );

   rfq_reader #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) reader_i (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .fifo_clr(fifo_clr),
      .commit(commit), .mem_q(mem_q), .head(head), .pending(frames_pending),
      .re(re), .raddr(raddr), .zero_q(zero_q)
   );

   assign rd_word = zero_q ? 32'd0 : mem_q;
   assign rx_irq  = (frames_pending != '0);
endmodule

// File: rtl/rfq_chk.sv
module rfq_chk #(
   parameter int unsigned SLOTS = 31,
   localparam int unsigned CW = $clog2(SLOTS + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_clr,
   input logic          rd_strobe,
   input logic [31:0]   rd_word,
   input logic [CW-1:0] frames_pending,
   input logic          rx_irq,
   input logic          frame_stored,
   input logic          overflow_evt
);
   // R1
   pending_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frames_pending <= CW'(SLOTS));

   // R8
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> frames_pending == '0);

   // R10
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && frames_pending == '0) |=> rd_word == 32'd0);

   // R4
   events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_stored && overflow_evt));

   // R11
   stored_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stored |-> rx_irq);

   // R7
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_clr |=> (frames_pending == $past(frames_pending) ||
                     frames_pending == $past(frames_pending) + CW'(1) ||
                     frames_pending == $past(frames_pending) - CW'(1)));
endmodule

bind rx_frame_queue rfq_chk #(.SLOTS(SLOTS)) chk_i (
   .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .rd_strobe(rd_strobe),
   .rd_word(rd_word), .frames_pending(frames_pending), .rx_irq(rx_irq),
   .frame_stored(frame_stored), .overflow_evt(overflow_evt)
);

// File: tb/rx_frame_queue_tb_top.sv
module rx_frame_queue_tb_top;
   localparam int SLOTS = 5;
   localparam int SLOT_BYTES = 64;
   localparam int THR = SLOT_BYTES - 6;
   localparam int CW = $clog2(SLOTS + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 0, in_first = 0, in_last = 0, rx_en = 1, fifo_clr = 0, rd_strobe = 0;
   logic [7:0] in_byte = 0;
   logic [31:0] in_crc = 0;
   logic [31:0] rd_word;
   logic [CW-1:0] frames_pending;
   logic rx_irq, frame_stored, overflow_evt;

   int checks = 0, errors = 0, stored_cnt = 0, ovf_cnt = 0;

   always #2 clk = ~clk;

   rx_frame_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_byte(in_byte), .in_crc(in_crc), .rx_en(rx_en),
      .fifo_clr(fifo_clr), .rd_strobe(rd_strobe), .rd_word(rd_word),
      .frames_pending(frames_pending), .rx_irq(rx_irq),
      .frame_stored(frame_stored), .overflow_evt(overflow_evt)
   );

   always @(negedge clk) begin
      if (frame_stored) stored_cnt++;
      if (overflow_evt) ovf_cnt++;
   end

   function automatic logic [7:0] dbyte(int id, int k);
      return 8'((id * 29 + k * 7 + 3) & 255);
   endfunction

   function automatic logic [31:0] fcrc(int id);
      return 32'h1234_5600 + 32'(id) * 32'h0100_0301;
   endfunction

   function automatic logic [7:0] ebyte(int id, int size, int i);
      int len = size + 6;
      logic [31:0] c = fcrc(id);
      if (i == 0) return 8'(len & 255);
      if (i == 1) return 8'(len >> 8);
      if (i < size + 2) return dbyte(id, i - 2);
      if (i < size + 6) return c[8*(i-2-size) +: 8];
      return 8'd0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(int id, int size);
      for (int k = 0; k < size; k++) begin
         @(negedge clk);
         in_valid = 1; in_first = (k == 0); in_last = (k == size - 1);
         in_byte = dbyte(id, k); in_crc = (k == size - 1) ? fcrc(id) : 32'd0;
      end
      @(negedge clk);
      in_valid = 0; in_first = 0; in_last = 0;
      repeat (9) @(negedge clk);
   endtask

   task automatic rd(output logic [31:0] w);
      @(negedge clk); rd_strobe = 1;
      @(negedge clk); rd_strobe = 0;
      w = rd_word;
   endtask

   task automatic read_frame(int id, int size, string req);
      logic [31:0] w, e;
      int n = (size + 9) / 4;
      for (int j = 0; j < n; j++) begin
         rd(w);
         for (int b = 0; b < 4; b++) e[8*b +: 8] = ebyte(id, size, 4*j + b);
         chk(req, w, e);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] w;
      int s0, o0, p0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset pending", 32'(frames_pending), 0);
      chk("R9 reset irq", 32'(rx_irq), 0);
      chk("R6 reset word", rd_word, 0);

      // R10 empty read
      rd(w);
      chk("R10 empty read word", w, 0);
      chk("R10 empty read pending", 32'(frames_pending), 0);

      // R5 R6 R7 R9 R11 size sweep
      for (int sz = 1; sz <= 14; sz++) begin
         s0 = stored_cnt;
         send(sz, sz);
         chk("R11 stored event", 32'(stored_cnt - s0), 1);
         chk("R9 irq with frame", 32'(rx_irq), 1);
         read_frame(sz, sz, "R5 image word");
         chk("R7 pending after last word", 32'(frames_pending), 0);
         chk("R9 irq after drain", 32'(rx_irq), 0);
      end

      // R1 R3 fill, overflow of slots, wrap
      for (int i = 0; i < SLOTS; i++) send(20 + i, 3 + i);
      chk("R1 pending full", 32'(frames_pending), SLOTS);
      s0 = stored_cnt;
      send(25, 6);
      chk("R3 full drop pending", 32'(frames_pending), SLOTS);
      chk("R3 full drop event", 32'(stored_cnt - s0), 0);
      read_frame(20, 3, "R1 order word");
      read_frame(21, 4, "R1 order word");
      chk("R7 pending after two", 32'(frames_pending), SLOTS - 2);
      send(26, 9);
      send(27, 2);
      chk("R1 pending refill", 32'(frames_pending), SLOTS);
      read_frame(22, 5, "R1 wrap word");
      read_frame(23, 6, "R1 wrap word");
      read_frame(24, 7, "R1 wrap word");
      read_frame(26, 9, "R3 wrap word");
      read_frame(27, 2, "R1 wrap word");
      chk("R1 drained", 32'(frames_pending), 0);

      // R2 disabled receive
      rx_en = 0;
      s0 = stored_cnt;
      send(30, 8);
      chk("R2 disabled pending", 32'(frames_pending), 0);
      chk("R2 disabled event", 32'(stored_cnt - s0), 0);
      rx_en = 1;
      rd(w);
      chk("R10 read after drop", w, 0);

      // R4 oversize boundary
      o0 = ovf_cnt; s0 = stored_cnt;
      send(31, THR);
      chk("R4 oversize event", 32'(ovf_cnt - o0), 1);
      chk("R4 oversize not stored", 32'(frames_pending), 0);
      chk("R4 oversize no store event", 32'(stored_cnt - s0), 0);
      o0 = ovf_cnt;
      send(32, THR - 1);
      chk("R4 limit no event", 32'(ovf_cnt - o0), 0);
      chk("R4 limit stored", 32'(frames_pending), 1);
      read_frame(32, THR - 1, "R4 limit word");
      chk("R7 limit drained", 32'(frames_pending), 0);

      // R8 clear mid-read
      send(33, 10);
      send(34, 11);
      rd(w);
      @(negedge clk); fifo_clr = 1;
      @(negedge clk); fifo_clr = 0;
      chk("R8 clear pending", 32'(frames_pending), 0);
      chk("R9 clear irq", 32'(rx_irq), 0);
      send(35, 5);
      p0 = frames_pending;
      chk("R8 after clear pending", 32'(p0), 1);
      read_frame(35, 5, "R8 after clear word");
      chk("R8 after clear drained", 32'(frames_pending), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule